// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data on a single clock between a narrow port A (12 bits by default) and a wide port B that is twice as wide. Port B is made of a low half (1B, bits `NW-1:0`) and a high half (2B, bits `2*NW-1:NW`).

In the A-to-B direction, the low half passes through two register stages and the high half through one. Two narrow words presented on consecutive edges therefore leave the block side by side as one wide word. The earlier word lands in 1B and the later word in 2B. In the B-to-A direction, each half of B has its own capture register, and a registered select puts one of them on port A.

Each port has an active-low output enable. The enable is registered and exposed as an active-high drive signal, so it can control an external three-state buffer. The data-out buses always carry the register contents, whatever the drive state. A synchronous active-high reset clears all data registers, sets the select to the low half and turns both drives off.

Top module: `nw_bus_exchanger`

## Requirements
- R1: While `rst` is high at a rising edge, every data register is cleared to zero, the registered select is set to the low half, and both `a_drive` and `b_drive` become 0. One edge after reset, `a_out` and `b_out` are all zeros.
- R2: The low half of `b_out` (bits NW-1:0) is fed by two registers in series.
  - The first stage captures `a_in` at a rising edge when `a1_ce_n` is 0.
  - The second stage copies the first stage at a rising edge when `a2_ce_n` is 0.
  - As a result, a word captured by the first stage appears on `b_out[NW-1:0]` one edge after it was captured.
- R3: The high half of `b_out` (bits 2*NW-1:NW) is a single register. It captures `a_in` at a rising edge when `a2_ce_n` is 0, and the value is visible right after that edge.
- R4: Suppose word N is on `a_in` with `a1_ce_n`=0 and `a2_ce_n`=1 at one edge, and word N+1 is on `a_in` with `a1_ce_n`=1 and `a2_ce_n`=0 at the next edge. After that second edge, `b_out` equals {N+1, N}.
- R5: A data register whose active-low enable is 1 at an edge keeps its value, whatever its data input carries.
- R6: The B-side low register captures `b_in[NW-1:0]` when `b1_ce_n` is 0. The B-side high register captures `b_in[2*NW-1:NW]` when `b2_ce_n` is 0.
- R7: `half_sel` is registered. `a_out` shows the B-side low register while the registered select is 0, and the high register while it is 1. A new `half_sel` value has no effect on `a_out` before the next rising edge.
- R8: `a_drive` equals the inverse of `oea_n` as sampled at the previous rising edge, and `b_drive` the inverse of `oeb_n` likewise. A change on an enable input has no effect before the next rising edge.
- R9: `a_out` and `b_out` carry the register contents regardless of `a_drive` and `b_drive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | NW | Narrow port input data |
| a1_ce_n | input | 1 | Active-low enable, first stage of the low-half path |
| a2_ce_n | input | 1 | Active-low enable, second low-half stage and high-half register |
| a_out | output | NW | Narrow port output data (selected B-side half) |
| a_drive | output | 1 | Narrow port drive enable, active high |
| b_in | input | 2*NW | Wide port input data |
| b1_ce_n | input | 1 | Active-low enable, B-side low-half capture |
| b2_ce_n | input | 1 | Active-low enable, B-side high-half capture |
| half_sel | input | 1 | Half select for port A (0 low, 1 high), registered |
| b_out | output | 2*NW | Wide port output data {2B, 1B} |
| b_drive | output | 1 | Wide port drive enable, active high |
| oea_n | input | 1 | Active-low output enable for port A, registered |
| oeb_n | input | 1 | Active-low output enable for port B, registered |

## Verification
Two functions can fall on the same edge: a B-side capture and a registered select change, or a drive turn-on. The bench provokes this by lowering `b2_ce_n`, flipping `half_sel` and lowering `oea_n` together before one edge. It first confirms that `a_out` and `a_drive` still show the old state before that edge. It then checks that after the edge `a_out` shows the freshly captured high half and `a_drive` is 1, with no intermediate state.

// File: rtl/bxc_pkg.sv
package bxc_pkg;
  localparam int HALVES    = 2;
  localparam int SEL_W     = $clog2(HALVES);
  localparam logic OFF_N   = 1'b1;
endpackage

// File: rtl/bxc_cap_reg.sv
module bxc_cap_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (!ce_n) q <= d;
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> $stable(q)) else $error("hold"); // R5
endmodule

// File: rtl/bxc_ctl.sv
module bxc_ctl
  import bxc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sel_in,
  input  logic oea_n,
  input  logic oeb_n,
  output logic sel_q,
  output logic a_drive,
  output logic b_drive
);
  logic oea_q_n, oeb_q_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      oea_q_n <= OFF_N;
      oeb_q_n <= OFF_N;
    end else begin
      sel_q   <= sel_in;
      oea_q_n <= oea_n;
      oeb_q_n <= oeb_n;
    end
  end

  assign a_drive = !oea_q_n;
  assign b_drive = !oeb_q_n;

  AST_SEL_LAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> sel_q == $past(sel_in)) else $error("sel lag"); // R7
  AST_OEA_LAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> a_drive == !$past(oea_n)) else $error("oea lag"); // R8
  AST_OEB_LAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> b_drive == !$past(oeb_n)) else $error("oeb lag"); // R8
  AST_RST_OFF: assert property (@(posedge clk)
    rst |=> !a_drive && !b_drive) else $error("reset drive"); // R1
endmodule

// File: rtl/bxc_a2b.sv
module bxc_a2b #(
  parameter int NW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] a_in,
  input  logic          a1_ce_n,
  input  logic          a2_ce_n,
  output logic [2*NW-1:0] b_data
);
  logic [NW-1:0] stage1, lo_q, hi_q;

  bxc_cap_reg #(.W(NW)) u_stage1 (
    .clk(clk), .rst(rst), .ce_n(a1_ce_n), .d(a_in), .q(stage1));
  bxc_cap_reg #(.W(NW)) u_lo (
    .clk(clk), .rst(rst), .ce_n(a2_ce_n), .d(stage1), .q(lo_q));
  bxc_cap_reg #(.W(NW)) u_hi (
    .clk(clk), .rst(rst), .ce_n(a2_ce_n), .d(a_in), .q(hi_q));

  assign b_data = {hi_q, lo_q};

  AST_LO_FROM_STAGE1: assert property (@(posedge clk) disable iff (rst)
    !a2_ce_n |=> b_data[NW-1:0] == $past(stage1)) else $error("lo"); // R2
  AST_HI_FROM_A: assert property (@(posedge clk) disable iff (rst)
    !a2_ce_n |=> b_data[2*NW-1:NW] == $past(a_in)) else $error("hi"); // R3
  AST_PAIR: assert property (@(posedge clk) disable iff (rst)
    (!a1_ce_n && a2_ce_n) ##1 (a1_ce_n && !a2_ce_n) |=>
      b_data == {$past(a_in), $past(a_in, 2)}) else $error("pair"); // R4
endmodule

// File: rtl/bxc_b2a.sv
module bxc_b2a
  import bxc_pkg::*;
#(
  parameter int NW = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [HALVES*NW-1:0] b_in,
  input  logic [HALVES-1:0]    ce_n,
  input  logic                sel_q,
  output logic [NW-1:0]       a_data
);
  logic [NW-1:0] held [HALVES];

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    bxc_cap_reg #(.W(NW)) u_cap (
      .clk(clk), .rst(rst), .ce_n(ce_n[h]),
      .d(b_in[h*NW +: NW]), .q(held[h]));

    AST_HALF_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      !ce_n[h] |=> held[h] == $past(b_in[h*NW +: NW])) else $error("cap"); // R6
  end

  always_comb begin
    a_data = held[0];
    if (sel_q) a_data = held[1];
  end
endmodule

// File: rtl/nw_bus_exchanger.sv
module nw_bus_exchanger
  import bxc_pkg::*;
#(
  parameter int NW = 12,
  localparam int BW = HALVES * NW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] a_in,
  input  logic          a1_ce_n,
  input  logic          a2_ce_n,
  output logic [NW-1:0] a_out,
  output logic          a_drive,
  input  logic [BW-1:0] b_in,
  input  logic          b1_ce_n,
  input  logic          b2_ce_n,
  input  logic          half_sel,
  output logic [BW-1:0] b_out,
  output logic          b_drive,
  input  logic          oea_n,
  input  logic          oeb_n
);
  logic sel_q;

  bxc_ctl u_ctl (
    .clk(clk), .rst(rst), .sel_in(half_sel), .oea_n(oea_n), .oeb_n(oeb_n),
    .sel_q(sel_q), .a_drive(a_drive), .b_drive(b_drive));

  bxc_a2b #(.NW(NW)) u_a2b (
    .clk(clk), .rst(rst), .a_in(a_in), .a1_ce_n(a1_ce_n), .a2_ce_n(a2_ce_n),
    .b_data(b_out));

  bxc_b2a #(.NW(NW)) u_b2a (
    .clk(clk), .rst(rst), .b_in(b_in), .ce_n({b2_ce_n, b1_ce_n}),
    .sel_q(sel_q), .a_data(a_out));

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> b_out == '0 && a_out == '0) else $error("reset data"); // R1
endmodule

// File: tb/nw_bus_exchanger_test.sv
module nw_bus_exchanger_test;
  localparam int NW = 12;
  localparam int BW = 2 * NW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0] a_in = '0;
  logic a1_ce_n = 1'b1, a2_ce_n = 1'b1;
  logic [NW-1:0] a_out;
  logic a_drive, b_drive;
  logic [BW-1:0] b_in = '0;
  logic b1_ce_n = 1'b1, b2_ce_n = 1'b1;
  logic half_sel = 1'b0;
  logic [BW-1:0] b_out;
  logic oea_n = 1'b1, oeb_n = 1'b1;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nw_bus_exchanger #(.NW(NW)) uut (
    .clk(clk), .rst(rst), .a_in(a_in), .a1_ce_n(a1_ce_n), .a2_ce_n(a2_ce_n),
    .a_out(a_out), .a_drive(a_drive), .b_in(b_in), .b1_ce_n(b1_ce_n),
    .b2_ce_n(b2_ce_n), .half_sel(half_sel), .b_out(b_out), .b_drive(b_drive),
    .oea_n(oea_n), .oeb_n(oeb_n));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [BW-1:0] act,
                     input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NW-1:0] pat(input int i, input int k);
    return NW'((i * k + 17 * k + 3) % 4096);
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NW-1:0] w0, w1, x1, x2, y, h1, h2;
    logic [BW-1:0] snap;
    repeat (3) tick();
    // R1: reset state
    chk("R1 a_drive", BW'(a_drive), '0);
    chk("R1 b_drive", BW'(b_drive), '0);
    chk("R1 b_out", b_out, '0);
    chk("R1 a_out", BW'(a_out), '0);
    rst = 1'b0;
    tick();
    chk("R1 b_out after", b_out, '0);

    // R4 sweep: pair assembly; R5 hold; R9 data valid while drive off
    for (int i = 0; i < 64; i++) begin
      w0 = pat(i, 293);
      w1 = pat(i, 1117);
      a_in = w0; a1_ce_n = 1'b0; a2_ce_n = 1'b1;
      tick();
      a_in = w1; a1_ce_n = 1'b1; a2_ce_n = 1'b0;
      tick();
      chk("R4 pair", b_out, {w1, w0});
      a_in = ~w1; a1_ce_n = 1'b1; a2_ce_n = 1'b1;
      tick();
      chk("R5 hold", b_out, {w1, w0});
    end
    chk("R9 b_out while b_drive low", BW'(b_drive), '0);
    snap = b_out;

    // R2/R3: both enables low on consecutive edges
    x1 = 12'h5A3; x2 = 12'hC3C;
    a_in = x1; a1_ce_n = 1'b0; a2_ce_n = 1'b0;
    tick();
    chk("R3 hi captures", BW'(b_out[BW-1:NW]), BW'(x1));
    chk("R2 lo from old stage1", BW'(b_out[NW-1:0]), BW'(w0));
    a_in = x2;
    tick();
    chk("R2 lo lags one edge", BW'(b_out[NW-1:0]), BW'(x1));
    chk("R3 hi next", BW'(b_out[BW-1:NW]), BW'(x2));
    // R3 alone: only a2_ce_n low
    y = 12'h0F1;
    a_in = y; a1_ce_n = 1'b1; a2_ce_n = 1'b0;
    tick();
    chk("R3 hi only", b_out, {y, x2});
    // R5: stage1 held while a1_ce_n high
    a_in = 12'h777;
    tick();
    chk("R5 stage1 held", b_out, {12'h777, x2});
    a2_ce_n = 1'b1;
    if (snap == '0) chk("R9 snap nonzero", 1, 0);

    // R6/R7 sweep on B to A path
    for (int i = 0; i < 32; i++) begin
      h1 = pat(i, 811); h2 = pat(i, 2003);
      half_sel = 1'b0;
      b_in = {h2, h1}; b1_ce_n = 1'b0; b2_ce_n = 1'b0;
      tick();
      chk("R6 lo capture", BW'(a_out), BW'(h1));
      b_in = {~h2, ~h1}; b1_ce_n = 1'b1; b2_ce_n = 1'b1;
      half_sel = 1'b1;
      #1;
      chk("R7 sel not yet", BW'(a_out), BW'(h1));
      tick();
      chk("R6 hi capture R7 sel hi", BW'(a_out), BW'(h2));
      half_sel = 1'b0;
      tick();
      chk("R5 b-side hold R7 sel lo", BW'(a_out), BW'(h1));
    end

    // R8 output enables
    oea_n = 1'b0;
    #1;
    chk("R8 a_drive before edge", BW'(a_drive), '0);
    tick();
    chk("R8 a_drive on", BW'(a_drive), 1);
    chk("R8 b_drive still off", BW'(b_drive), '0);
    oeb_n = 1'b0;
    tick();
    chk("R8 b_drive on", BW'(b_drive), 1);
    oea_n = 1'b1;
    #1;
    chk("R8 a_drive holds before edge", BW'(a_drive), 1);
    tick();
    chk("R8 a_drive off", BW'(a_drive), '0);
    chk("R9 a_out unaffected by drive", BW'(a_out), BW'(h1));

    // Same edge: capture high half, flip select, enable A drive
    b_in = {12'hABC, 12'h123}; b2_ce_n = 1'b0; half_sel = 1'b1; oea_n = 1'b0;
    #1;
    chk("R7 same-edge before", BW'(a_out), BW'(h1));
    chk("R8 same-edge before", BW'(a_drive), '0);
    tick();
    chk("R6 R7 same-edge after", BW'(a_out), BW'(12'hABC));
    chk("R8 same-edge after", BW'(a_drive), 1);
    b2_ce_n = 1'b1;

    // R1 again: reset mid-run
    rst = 1'b1;
    tick();
    chk("R1 reset mid b_out", b_out, '0);
    chk("R1 reset mid a_out", BW'(a_out), '0);
    chk("R1 reset mid drives", BW'({a_drive, b_drive}), '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule